// File: doc/BRIEF.md
# Redundant Sub-Bit Encoder with Phase-Inverting Carrier

This block turns a serial stream of command bits into a redundant, phase-keyed carrier. Each bit taken from an upstream shift register expands into a fixed five-symbol codeword. The codeword set depends on a per-bit flag. Bits flagged as vehicle-address bits use one set and message bits use a complementary-pair set of their own, so a receiver can find where a message starts. The codeword symbols ("sub-bits") leave most significant first, one per sub-bit period.

The block produces a square-wave carrier with a parameterised whole number of periods per sub-bit period. A sub-bit of 0 inverts the carrier by 180 degrees and a sub-bit of 1 passes it unchanged. Inversions happen only on sub-bit boundaries. When no bit is in flight, the output is the plain carrier. The raw sub-bit stream and a one-cycle strobe at the start of each sub-bit are also brought out, so that a receiver's recovered sub-bits can be compared against them in a loopback.

Upstream supplies bits through a ready/valid pair. The block keeps one bit of look-ahead, so consecutive bits leave without a gap. With the default setting of one sub-bit per 100 000 clocks on a 100 MHz clock, the sub-bit rate is 1000 per second and the bit rate is 200 per second.

Top module: `subbit_psk_enc`

## Requirements
- R1: While reset is held, and in the first cycle after it: psk_out is 1, sub_bit is 1, tx_active is 0, sub_stb is 0 and bit_ready is 1.
- R2: A message bit (bit_addr = 0) of value 1 is sent as sub-bits 0,1,0,1,1 in that time order. A message bit of value 0 is sent as 1,0,1,0,0.
- R3: An address bit (bit_addr = 1) of value 1 is sent as 0,0,1,1,1 in time order. An address bit of value 0 is sent as 1,1,0,0,0.
- R4: Each sub-bit lasts exactly CLK_PER_SUBBIT clock cycles. Sub-bit boundaries fall at whole multiples of CLK_PER_SUBBIT cycles after reset is released. sub_stb is a single-cycle pulse in the first cycle of every transmitted sub-bit, and sub_bit does not change elsewhere within a transmission.
- R5: The carrier is 1 for CLK_PER_SUBBIT/(2·CARRIER_MULT) cycles and then 0 for the same length, repeating. It starts high on release of reset. While tx_active is 1, psk_out equals the carrier when sub_bit is 1 and its inverse when sub_bit is 0. A change of inversion happens only on a sub-bit boundary.
- R6: While tx_active is 0, psk_out follows the carrier with no inversion, sub_bit is 1 and sub_stb stays 0.
- R7: A bit transfers on a clock edge where bit_valid and bit_ready are both 1. bit_ready is 1 only when the look-ahead slot is empty and either nothing is being sent or the fifth sub-bit of the current bit is on the line. It is 0 in the cycle after a transfer.
- R8: Bits supplied in time leave back to back: the first sub-bit of the next bit follows the fifth sub-bit of the previous one with no idle period. This holds even when the transfer falls on the very edge that ends a sub-bit. A bit accepted while idle starts at the next sub-bit boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Upstream offers a bit |
| bit_data | input | 1 | Value of the offered bit |
| bit_addr | input | 1 | Offered bit belongs to the vehicle address (selects codeword set) |
| bit_ready | output | 1 | Block will take a bit on this edge if offered |
| psk_out | output | 1 | Phase-keyed square-wave carrier |
| sub_bit | output | 1 | Sub-bit currently on the line (1 when idle) |
| sub_stb | output | 1 | One-cycle pulse at the start of each transmitted sub-bit |
| tx_active | output | 1 | A codeword is being transmitted |

## Verification
Two events can land on the same edge: the upstream transfer of a new bit and the sub-bit boundary that ends the fifth sub-bit, or the boundary that would start a bit from idle. In that case the codeword must load straight from the incoming bit without passing through the look-ahead slot. The bench provokes this by holding back bit_valid until the cycle just before a boundary, both in the middle of a message and from idle. It judges the result by the spacing of sub_stb pulses, the codeword symbols collected, and the absence of any uninverted idle period between bits.

// File: rtl/subbit_psk_pkg.sv
package subbit_psk_pkg;

   // Number of sub-bits in one codeword.
   localparam int unsigned SUB_N = 5;

   // Codewords for a bit of value 1; a bit of value 0 uses the complement.
   localparam logic [SUB_N-1:0] MSG_ONE_CW  = 5'b01011;
   localparam logic [SUB_N-1:0] ADDR_ONE_CW = 5'b00111;

   // Pick the codeword for a bit value, given the codeword for a one.
   function automatic logic [SUB_N-1:0] cw_pick(input logic [SUB_N-1:0] one_cw,
                                                input logic             val);
      return val ? one_cw : ~one_cw;
   endfunction

endpackage

// File: rtl/subbit_psk_timer.sv
// Sub-bit period counter and carrier generator sharing one time base.
module subbit_psk_timer #(
   parameter int unsigned CLK_PER_SUBBIT = 8,
   parameter int unsigned HALF_PER       = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick,
   output logic carrier
);
   localparam int unsigned CW = (CLK_PER_SUBBIT > 1) ? $clog2(CLK_PER_SUBBIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_PER_SUBBIT - 1);

   logic [CW-1:0] per_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         per_cnt <= '0;
      end else if (per_cnt == LAST) begin
         per_cnt <= '0;
      end else begin
         per_cnt <= per_cnt + 1'b1;
      end
   end

   assign tick = (per_cnt == LAST);

   generate
      if (HALF_PER == 1) begin : g_car_fast
         always_ff @(posedge clk) begin
            if (rst) carrier <= 1'b1;
            else     carrier <= ~carrier;
         end
      end else begin : g_car_div
         localparam int unsigned HW = $clog2(HALF_PER);
         localparam logic [HW-1:0] HLAST = HW'(HALF_PER - 1);
         logic [HW-1:0] half_cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               half_cnt <= '0;
               carrier  <= 1'b1;
            end else if (half_cnt == HLAST) begin
               half_cnt <= '0;
               carrier  <= ~carrier;
            end else begin
               half_cnt <= half_cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/subbit_psk_serializer.sv
// Bit intake with one look-ahead slot and codeword shift-out.
module subbit_psk_serializer
   import subbit_psk_pkg::*;
#(
   parameter logic [SUB_N-1:0] MSG_CW  = MSG_ONE_CW,
   parameter logic [SUB_N-1:0] ADDR_CW = ADDR_ONE_CW
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic bit_valid,
   input  logic bit_data,
   input  logic bit_addr,
   output logic bit_ready,
   output logic sub_bit,
   output logic sub_stb,
   output logic active
);
   localparam int unsigned IW = $clog2(SUB_N);
   localparam logic [IW-1:0] IDX_LAST = IW'(SUB_N - 1);

   logic [SUB_N-1:0] shreg;
   logic [IW-1:0]    idx;
   logic             hold_v, hold_d, hold_a;
   logic             last_sub, xfer, take, src_v, src_d, src_a;
   logic [SUB_N-1:0] next_cw;

   assign last_sub  = active && (idx == IDX_LAST);
   assign bit_ready = !hold_v && (!active || last_sub);
   assign xfer      = bit_valid && bit_ready;
   assign take      = tick && (!active || last_sub);

   // Source for a new codeword: look-ahead slot first, else the bit arriving now.
   assign src_v = hold_v || xfer;
   assign src_d = hold_v ? hold_d : bit_data;
   assign src_a = hold_v ? hold_a : bit_addr;
   assign next_cw = src_a ? cw_pick(ADDR_CW, src_d) : cw_pick(MSG_CW, src_d);

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg   <= '1;
         idx     <= '0;
         active  <= 1'b0;
         hold_v  <= 1'b0;
         hold_d  <= 1'b0;
         hold_a  <= 1'b0;
         sub_stb <= 1'b0;
      end else begin
         sub_stb <= 1'b0;
         if (xfer && !take) begin
            hold_v <= 1'b1;
            hold_d <= bit_data;
            hold_a <= bit_addr;
         end
         if (tick) begin
            if (take) begin
               if (src_v) begin
                  shreg   <= next_cw;
                  idx     <= '0;
                  active  <= 1'b1;
                  sub_stb <= 1'b1;
                  hold_v  <= 1'b0;
               end else begin
                  shreg  <= '1;
                  idx    <= '0;
                  active <= 1'b0;
               end
            end else begin
               shreg   <= {shreg[SUB_N-2:0], 1'b1};
               idx     <= idx + 1'b1;
               sub_stb <= 1'b1;
            end
         end
      end
   end

   assign sub_bit = shreg[SUB_N-1];

endmodule

// File: rtl/subbit_psk_enc.sv
// Sub-bit encoder with phase-inverting square-wave carrier.
module subbit_psk_enc
   import subbit_psk_pkg::*;
#(
   parameter int unsigned      CLK_PER_SUBBIT = 100000,
   parameter int unsigned      CARRIER_MULT   = 2,
   parameter logic [SUB_N-1:0] MSG_CW         = MSG_ONE_CW,
   parameter logic [SUB_N-1:0] ADDR_CW        = ADDR_ONE_CW
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_valid,
   input  logic bit_data,
   input  logic bit_addr,
   output logic bit_ready,
   output logic psk_out,
   output logic sub_bit,
   output logic sub_stb,
   output logic tx_active
);
   localparam int unsigned HALF_PER = CLK_PER_SUBBIT / (2 * CARRIER_MULT);

   generate
      if (CARRIER_MULT < 1) begin : g_bad_mult
         $error("CARRIER_MULT must be at least 1");
      end
      if (CLK_PER_SUBBIT % (2 * CARRIER_MULT) != 0) begin : g_bad_div
         $error("CLK_PER_SUBBIT must be a multiple of 2*CARRIER_MULT");
      end
      if (MSG_CW == ADDR_CW || MSG_CW == ~ADDR_CW) begin : g_bad_cw
         $error("address codewords must differ from message codewords");
      end
      if (MSG_CW == ~MSG_CW) begin : g_bad_pair
         $error("codeword pair must be distinct");
      end
   endgenerate

   logic tick;
   logic carrier;

   subbit_psk_timer #(
      .CLK_PER_SUBBIT(CLK_PER_SUBBIT),
      .HALF_PER      (HALF_PER)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .carrier(carrier)
   );

   subbit_psk_serializer #(
      .MSG_CW (MSG_CW),
      .ADDR_CW(ADDR_CW)
   ) u_ser (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .bit_valid(bit_valid),
      .bit_data (bit_data),
      .bit_addr (bit_addr),
      .bit_ready(bit_ready),
      .sub_bit  (sub_bit),
      .sub_stb  (sub_stb),
      .active   (tx_active)
   );

   // A zero sub-bit flips the carrier by half a period.
   assign psk_out = carrier ^ (tx_active & ~sub_bit);

endmodule

// File: rtl/subbit_psk_chk.sv
module subbit_psk_chk (
   input logic clk,
   input logic rst,
   input logic tick,
   input logic carrier,
   input logic bit_valid,
   input logic bit_ready,
   input logic psk_out,
   input logic sub_bit,
   input logic sub_stb,
   input logic tx_active
);
   AST_STB_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      sub_stb |-> $past(tick)); // R4
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      sub_stb |=> !sub_stb); // R4
   AST_SUBBIT_HELD: assert property (@(posedge clk) disable iff (rst)
      (tx_active && $past(tx_active) && !sub_stb) |-> $stable(sub_bit)); // R4
   AST_INVERT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      !$stable(psk_out ^ carrier) |-> $past(tick)); // R5
   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
      !tx_active |-> (sub_bit && !sub_stb)); // R6
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && bit_ready) |=> !bit_ready); // R7
endmodule

bind subbit_psk_enc subbit_psk_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick),
   .carrier  (carrier),
   .bit_valid(bit_valid),
   .bit_ready(bit_ready),
   .psk_out  (psk_out),
   .sub_bit  (sub_bit),
   .sub_stb  (sub_stb),
   .tx_active(tx_active)
);

// File: tb/subbit_psk_enc_tb_top.sv
`timescale 1ns/1ps
module subbit_psk_enc_tb_top;
   localparam int CPS  = 8;
   localparam int MULT = 2;
   localparam int HALF = CPS / (2 * MULT);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_valid = 1'b0, bit_data = 1'b0, bit_addr = 1'b0;
   logic bit_ready, psk_out, sub_bit, sub_stb, tx_active;

   always #5 clk = ~clk;

   subbit_psk_enc #(.CLK_PER_SUBBIT(CPS), .CARRIER_MULT(MULT)) dut_i (
      .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
      .bit_addr(bit_addr), .bit_ready(bit_ready), .psk_out(psk_out),
      .sub_bit(sub_bit), .sub_stb(sub_stb), .tx_active(tx_active));

   int checks = 0;
   int fails  = 0;
   int edges  = 0;          // clock edges since reset release
   logic exp_q[$];
   string tag_q[$];
   int stb_cnt, stb_first, stb_last;
   logic prev_sub;
   logic prev_act;

   always @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   function automatic logic car_exp(input int e);
      return ((e / HALF) % 2) == 0;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b (edge %0d)", req, what, act, exp, edges);
      end
   endtask

   // Continuous monitor, sampled on the falling edge.
   always @(negedge clk) begin
      if (!rst) begin
         chk("R5", psk_out, car_exp(edges) ^ (tx_active & ~sub_bit), "psk_out vs carrier");
         if (!tx_active) begin
            chk("R6", sub_bit, 1'b1, "idle sub_bit");
            chk("R6", psk_out, car_exp(edges), "idle psk_out");
            chk("R6", sub_stb, 1'b0, "idle sub_stb");
         end
         if (sub_stb) begin
            chk("R4", ((edges % CPS) == 0), 1'b1, "strobe alignment");
            if (exp_q.size() == 0) begin
               chk("R2", 1'b1, 1'b0, "unexpected sub-bit");
            end else begin
               chk(tag_q.pop_front(), sub_bit, exp_q.pop_front(), "sub-bit value");
            end
            if (stb_cnt == 0) stb_first = edges;
            stb_last = edges;
            stb_cnt++;
         end else if (tx_active && prev_act) begin
            chk("R4", sub_bit, prev_sub, "sub_bit held within period");
         end
         prev_sub = sub_bit;
         prev_act = tx_active;
      end
   end

   task automatic push_cw(input logic d, input logic a);
      logic [4:0] cw;
      cw = a ? (d ? 5'b00111 : 5'b11000) : (d ? 5'b01011 : 5'b10100);
      for (int i = 4; i >= 0; i--) begin
         exp_q.push_back(cw[i]);
         tag_q.push_back(a ? "R3" : "R2");
      end
   endtask

   // Offer one bit; when at_edge is set, hold it back until the cycle before a boundary.
   task automatic send_bit(input logic d, input logic a, input bit at_edge);
      @(negedge clk);
      while (!bit_ready || (at_edge && (edges % CPS) != CPS - 1)) @(negedge clk);
      push_cw(d, a);
      bit_valid = 1'b1; bit_data = d; bit_addr = a;
      @(posedge clk);
      #1 bit_valid = 1'b0;
      @(negedge clk);
      chk("R7", bit_ready, 1'b0, "ready after transfer");
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (tx_active || exp_q.size() != 0) @(negedge clk);
      repeat (2 * CPS) @(negedge clk);
   endtask

   task automatic start_msg();
      stb_cnt = 0; stb_first = 0; stb_last = 0;
   endtask

   task automatic end_msg(input int nbits, input string req);
      wait_idle();
      checks++;
      if (stb_cnt != 5 * nbits || (stb_last - stb_first) != CPS * (5 * nbits - 1)) begin
         fails++;
         $display("FAIL %s gapless run: actual %0d strobes span %0d expected %0d strobes span %0d",
                  req, stb_cnt, stb_last - stb_first, 5 * nbits, CPS * (5 * nbits - 1));
      end
      chk(req, exp_q.size() == 0, 1'b1, "all sub-bits sent");
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", psk_out, 1'b1, "reset psk_out");
      chk("R1", sub_bit, 1'b1, "reset sub_bit");
      chk("R1", tx_active, 1'b0, "reset tx_active");
      chk("R1", sub_stb, 1'b0, "reset sub_stb");
      chk("R1", bit_ready, 1'b1, "reset bit_ready");
      rst = 1'b0;
      @(negedge clk);
      chk("R1", psk_out, 1'b1, "first cycle psk_out");
      chk("R1", tx_active, 1'b0, "first cycle tx_active");
   endtask

   task automatic t_idle();
      repeat (5 * CPS) @(negedge clk);
      chk("R6", tx_active, 1'b0, "idle stays idle");
   endtask

   task automatic t_msg_bits();
      start_msg();
      send_bit(1'b1, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0);
      end_msg(3, "R2");
   endtask

   task automatic t_addr_bits();
      start_msg();
      send_bit(1'b1, 1'b1, 1'b0);
      send_bit(1'b0, 1'b1, 1'b0);
      send_bit(1'b1, 1'b1, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      end_msg(4, "R3");
   endtask

   task automatic t_ready_window();
      int k;
      start_msg();
      send_bit(1'b0, 1'b0, 1'b0);
      k = 0;
      while (k < 5) begin
         @(negedge clk);
         if (sub_stb) begin
            k++;
            chk("R7", bit_ready, (k == 5), $sformatf("ready at sub-bit %0d", k));
         end
      end
      end_msg(1, "R7");
   endtask

   task automatic t_boundary();
      start_msg();
      send_bit(1'b1, 1'b1, 1'b1);   // from idle, on the boundary edge
      send_bit(1'b0, 1'b0, 1'b1);   // mid-message, on the edge ending sub-bit five
      send_bit(1'b1, 1'b0, 1'b1);
      end_msg(3, "R8");
   endtask

   initial begin
      prev_sub = 1'b1; prev_act = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_idle();
      t_msg_bits();
      t_addr_bits();
      t_ready_window();
      t_boundary();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule